// File: doc/BRIEF.md
# Ring Command Queue Consumer

This block drains a ring of fixed-size command entries held in system memory. Software sets where the ring lives and how many pages it spans, then advances a producer index. While the block is enabled and the consumer index trails the producer index, the block reads the first 64-bit word of the entry at the consumer index. It takes the command code from that word and either hands the entry to a downstream executor or skips it.

A fetch that returns a bus error, or an executor that answers "stall", freezes the ring. The consumer index stays on the failing entry and a sticky stalled flag is raised. Unknown codes and the synchronisation code are skipped with no executor call. The block also enforces the write rules of its three software registers. The base register is locked while the block is enabled. A producer-index write can restart a frozen ring. The consumer index can only be written while a security-disable input is high.

Top module: `cmdq_consumer`

## Requirements
- R1: After reset the block is disabled, the stalled flag is clear, both indices are zero, and neither a fetch nor an executor request is active.
- R2: While the enable bit is clear, no entry is fetched.
- R3: The ring holds (size+1)*128 entries when the base valid bit (bit 63) is set, and zero entries otherwise. The size is bits [7:0] of the base register. If either index is not below that count, processing stops without a fetch and without changing any index.
- R4: An entry is fetched at byte address base + index*32. The base is bits [51:12] of the base register, shifted left by 12.
- R5: The command code is bits [7:0] of the fetched word. Codes 0x01 to 0x0F, except 0x05, go to the executor together with the word and the entry address. Code 0x05 and every other code advance the index without an executor call.
- R6: When a command completes without a stall, the consumer index becomes (index+1) modulo the entry count. Fetching continues until the two indices match.
- R7: When the executor answers stall, the stalled flag is set, the consumer index is unchanged and processing stops.
- R8: When a fetch returns a bus error, the stalled flag is set, the consumer index is unchanged and nothing is sent to the executor.
- R9: A producer-index write (select 2) takes the index from bits [19:5] and ignores bit 0. It starts processing when the new index differs from the consumer index, which retries a frozen ring.
- R10: A base write (select 1) is ignored while enabled. Otherwise it loads the base, zeroes both indices and clears the stalled flag.
- R11: A control write (select 0) sets the enable bit from bit 0. Writing 1 also zeroes the consumer index and starts processing. Writing 0 prevents further fetches.
- R12: A consumer-index write (select 3) takes effect only while sec_disable is high. It then loads bits [19:5], ignores bit 0 and clears the stalled flag. Otherwise it changes nothing.
- R13: The stalled flag remains set through later successful commands until R10 or R12 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select: 0 control, 1 base, 2 producer index, 3 consumer index |
| reg_wr_data | input | 64 | Register write data |
| sec_disable | input | 1 | Permits consumer-index writes when high |
| mem_req | output | 1 | Fetch request, held until mem_ack |
| mem_addr | output | 52 | Fetch byte address |
| mem_ack | input | 1 | Fetch response valid |
| mem_err | input | 1 | Fetch bus error, qualified by mem_ack |
| mem_rdata | input | 64 | First word of the fetched entry |
| exe_valid | output | 1 | Command offered to the executor |
| exe_op | output | 8 | Command code |
| exe_dword | output | 64 | First word of the entry |
| exe_addr | output | 52 | Byte address of the entry |
| exe_done | input | 1 | Executor finished the offered command |
| exe_stall | input | 1 | With exe_done: command must stall the ring |
| enable_o | output | 1 | Current enable bit |
| stalled_o | output | 1 | Sticky stalled flag |
| rd_off_o | output | 15 | Consumer index |
| wr_off_o | output | 15 | Producer index |

## Verification
The bench drives a wrap from index 127 back to index 0. A design whose modulo is off by one would fetch past the end of the ring or skip entry 0. It stalls the ring twice, once through the executor and once through a bus error. A wrong design would advance past the failing entry, or would drop the sticky flag after the retried command succeeds. It writes the base register while enabled and writes the consumer index without permission. A design that leaks those writes would zero or move an index visible at the ports. It also sets the producer index out of range and marks the base invalid. A design without the range check would fetch garbage.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_BASE = 2'd1,
    REG_WOFF = 2'd2,
    REG_ROFF = 2'd3
  } cq_reg_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FETCH = 2'd1,
    SEQ_EXEC  = 2'd2
  } cq_seq_e;

  localparam logic [7:0] OP_SYNC  = 8'h05;
  localparam logic [7:0] OP_FIRST = 8'h01;
  localparam logic [7:0] OP_LAST  = 8'h0F;

  // Codes that need the executor; everything else is consumed in place.
  function automatic logic op_dispatched(input logic [7:0] op);
    return (op >= OP_FIRST) && (op <= OP_LAST) && (op != OP_SYNC);
  endfunction

endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
  import cmdq_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned ADDR_W  = 52,
  parameter int unsigned SIZE_W  = 8,
  parameter int unsigned PAGE_LG = 12,
  parameter int unsigned ENT_LG  = 5,
  parameter int unsigned OFF_W   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sec_disable,
  input  logic              adv_en,
  input  logic [OFF_W-1:0]  adv_idx,
  input  logic              stall_set,
  output logic              enable_o,
  output logic              base_valid_o,
  output logic [SIZE_W-1:0] base_size_o,
  output logic [ADDR_W-1:0] base_addr_o,
  output logic [OFF_W-1:0]  woff_o,
  output logic [OFF_W-1:0]  roff_o,
  output logic              stalled_o,
  output logic              kick_o
);

  localparam int unsigned PFN_W = ADDR_W - PAGE_LG;

  logic              en_q, en_d;
  logic              bval_q, bval_d;
  logic [SIZE_W-1:0] bsize_q, bsize_d;
  logic [PFN_W-1:0]  bpfn_q, bpfn_d;
  logic [OFF_W-1:0]  woff_q, woff_d;
  logic [OFF_W-1:0]  roff_q, roff_d;
  logic              stall_q, stall_d;

  cq_reg_e          sel;
  logic [OFF_W-1:0] wr_idx;
  logic             ctrl_wr, base_wr, woff_wr, roff_wr, start;
  logic             unused_data;

  assign sel         = cq_reg_e'(wr_sel);
  assign wr_idx      = wr_data[OFF_W+ENT_LG-1:ENT_LG];
  assign unused_data = ^wr_data;

  assign ctrl_wr = wr_en && (sel == REG_CTRL);
  assign base_wr = wr_en && (sel == REG_BASE) && !en_q;
  assign woff_wr = wr_en && (sel == REG_WOFF);
  assign roff_wr = wr_en && (sel == REG_ROFF) && sec_disable;
  assign start   = ctrl_wr && wr_data[0];

  always_comb begin
    en_d    = en_q;
    bval_d  = bval_q;
    bsize_d = bsize_q;
    bpfn_d  = bpfn_q;
    woff_d  = woff_q;
    roff_d  = roff_q;
    stall_d = stall_q;

    if (ctrl_wr) en_d = wr_data[0];

    if (base_wr) begin
      bval_d  = wr_data[DATA_W-1];
      bsize_d = wr_data[SIZE_W-1:0];
      bpfn_d  = wr_data[ADDR_W-1:PAGE_LG];
    end

    if (base_wr)      woff_d = '0;
    else if (woff_wr) woff_d = wr_idx;

    // Software writes override a same-cycle hardware advance.
    if (adv_en) roff_d = adv_idx;
    if (start || base_wr) roff_d = '0;
    else if (roff_wr)     roff_d = wr_idx;

    if (stall_set) stall_d = 1'b1;
    if (base_wr || roff_wr) stall_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      bval_q  <= 1'b0;
      bsize_q <= '0;
      bpfn_q  <= '0;
      woff_q  <= '0;
      roff_q  <= '0;
      stall_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      bval_q  <= bval_d;
      bsize_q <= bsize_d;
      bpfn_q  <= bpfn_d;
      woff_q  <= woff_d;
      roff_q  <= roff_d;
      stall_q <= stall_d;
    end
  end

  assign kick_o       = start || (woff_wr && (wr_idx != roff_q));
  assign enable_o     = en_q;
  assign base_valid_o = bval_q;
  assign base_size_o  = bsize_q;
  assign base_addr_o  = {bpfn_q, {PAGE_LG{1'b0}}};
  assign woff_o       = woff_q;
  assign roff_o       = roff_q;
  assign stalled_o    = stall_q;

endmodule

// File: rtl/cmdq_ring.sv
module cmdq_ring #(
  parameter int unsigned ADDR_W      = 52,
  parameter int unsigned SIZE_W      = 8,
  parameter int unsigned ENT_LG      = 5,
  parameter int unsigned PER_PAGE_LG = 7,
  parameter int unsigned OFF_W       = 15
) (
  input  logic              base_valid,
  input  logic [SIZE_W-1:0] base_size,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [OFF_W-1:0]  roff,
  input  logic [OFF_W-1:0]  woff,
  output logic              in_range,
  output logic              pending,
  output logic [ADDR_W-1:0] entry_addr,
  output logic [OFF_W-1:0]  roff_next
);

  localparam int unsigned CNT_W = OFF_W + 1;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] inc;

  always_comb begin
    count = '0;
    if (base_valid) count = (CNT_W'(base_size) + CNT_W'(1)) << PER_PAGE_LG;
  end

  assign in_range   = ({1'b0, roff} < count) && ({1'b0, woff} < count);
  assign pending    = (roff != woff);
  assign inc        = {1'b0, roff} + CNT_W'(1);
  assign roff_next  = (inc == count) ? '0 : inc[OFF_W-1:0];
  assign entry_addr = base_addr + (ADDR_W'(roff) << ENT_LG);

endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
  import cmdq_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 52,
  parameter int unsigned OFF_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic              enable,
  input  logic              in_range,
  input  logic              pending,
  input  logic [ADDR_W-1:0] entry_addr,
  input  logic [OFF_W-1:0]  roff_next,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              exe_done,
  input  logic              exe_stall,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              exe_valid,
  output logic [7:0]        exe_op,
  output logic [DATA_W-1:0] exe_dword,
  output logic [ADDR_W-1:0] exe_addr,
  output logic              adv_en,
  output logic [OFF_W-1:0]  adv_idx,
  output logic              stall_set
);

  cq_seq_e           state_q, state_d;
  logic              run_q, run_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [OFF_W-1:0]  next_q, next_d;
  logic [DATA_W-1:0] dw_q, dw_d;

  always_comb begin
    state_d   = state_q;
    run_d     = run_q;
    addr_d    = addr_q;
    next_d    = next_q;
    dw_d      = dw_q;
    adv_en    = 1'b0;
    stall_set = 1'b0;

    case (state_q)
      SEQ_IDLE: begin
        if (run_q) begin
          if (enable && in_range && pending) begin
            state_d = SEQ_FETCH;
            addr_d  = entry_addr;
            next_d  = roff_next;
          end else begin
            run_d = 1'b0;
          end
        end
      end
      SEQ_FETCH: begin
        if (mem_ack) begin
          state_d = SEQ_IDLE;
          if (mem_err) begin
            stall_set = 1'b1;
            run_d     = 1'b0;
          end else if (op_dispatched(mem_rdata[7:0])) begin
            dw_d    = mem_rdata;
            state_d = SEQ_EXEC;
          end else begin
            adv_en = 1'b1;
          end
        end
      end
      SEQ_EXEC: begin
        if (exe_done) begin
          state_d = SEQ_IDLE;
          if (exe_stall) begin
            stall_set = 1'b1;
            run_d     = 1'b0;
          end else begin
            adv_en = 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase

    if (kick) run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      run_q   <= 1'b0;
      addr_q  <= '0;
      next_q  <= '0;
      dw_q    <= '0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
      addr_q  <= addr_d;
      next_q  <= next_d;
      dw_q    <= dw_d;
    end
  end

  assign mem_req   = (state_q == SEQ_FETCH);
  assign mem_addr  = addr_q;
  assign exe_valid = (state_q == SEQ_EXEC);
  assign exe_op    = dw_q[7:0];
  assign exe_dword = dw_q;
  assign exe_addr  = addr_q;
  assign adv_idx   = next_q;

endmodule

// File: rtl/cmdq_consumer.sv
module cmdq_consumer #(
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned ADDR_W      = 52,
  parameter int unsigned SIZE_W      = 8,
  parameter int unsigned PAGE_BYTES  = 4096,
  parameter int unsigned ENTRY_BYTES = 32,
  localparam int unsigned PAGE_LG     = $clog2(PAGE_BYTES),
  localparam int unsigned ENT_LG      = $clog2(ENTRY_BYTES),
  localparam int unsigned PER_PAGE_LG = PAGE_LG - ENT_LG,
  localparam int unsigned OFF_W       = SIZE_W + PER_PAGE_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_sel,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic              sec_disable,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              exe_valid,
  output logic [7:0]        exe_op,
  output logic [DATA_W-1:0] exe_dword,
  output logic [ADDR_W-1:0] exe_addr,
  input  logic              exe_done,
  input  logic              exe_stall,
  output logic              enable_o,
  output logic              stalled_o,
  output logic [OFF_W-1:0]  rd_off_o,
  output logic [OFF_W-1:0]  wr_off_o
);

  logic              base_valid;
  logic [SIZE_W-1:0] base_size;
  logic [ADDR_W-1:0] base_addr;
  logic              kick, adv_en, stall_set, in_range, pending;
  logic [OFF_W-1:0]  adv_idx, roff_next;
  logic [ADDR_W-1:0] entry_addr;

  cmdq_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
    .PAGE_LG(PAGE_LG), .ENT_LG(ENT_LG), .OFF_W(OFF_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
    .sec_disable(sec_disable),
    .adv_en(adv_en), .adv_idx(adv_idx), .stall_set(stall_set),
    .enable_o(enable_o), .base_valid_o(base_valid), .base_size_o(base_size),
    .base_addr_o(base_addr), .woff_o(wr_off_o), .roff_o(rd_off_o),
    .stalled_o(stalled_o), .kick_o(kick)
  );

  cmdq_ring #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .ENT_LG(ENT_LG),
    .PER_PAGE_LG(PER_PAGE_LG), .OFF_W(OFF_W)
  ) u_ring (
    .base_valid(base_valid), .base_size(base_size), .base_addr(base_addr),
    .roff(rd_off_o), .woff(wr_off_o),
    .in_range(in_range), .pending(pending),
    .entry_addr(entry_addr), .roff_next(roff_next)
  );

  cmdq_seq #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .kick(kick), .enable(enable_o),
    .in_range(in_range), .pending(pending),
    .entry_addr(entry_addr), .roff_next(roff_next),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .exe_done(exe_done), .exe_stall(exe_stall),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .exe_valid(exe_valid), .exe_op(exe_op), .exe_dword(exe_dword),
    .exe_addr(exe_addr),
    .adv_en(adv_en), .adv_idx(adv_idx), .stall_set(stall_set)
  );

endmodule

// File: rtl/cmdq_consumer_chk.sv
module cmdq_consumer_chk
  import cmdq_pkg::*;
#(
  parameter int unsigned ADDR_W = 52,
  parameter int unsigned OFF_W  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [1:0]        reg_wr_sel,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              mem_err,
  input logic              exe_valid,
  input logic              exe_done,
  input logic              exe_stall,
  input logic              enable_o,
  input logic              stalled_o,
  input logic [OFF_W-1:0]  rd_off_o,
  input logic [OFF_W-1:0]  wr_off_o
);

  // R2
  fetch_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(enable_o));

  // R5
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, exe_valid}));

  // R4
  fetch_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R8
  fetch_err_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err && !reg_wr_en) |=> (stalled_o && $stable(rd_off_o)));

  // R7
  exec_stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_valid && exe_done && exe_stall && !reg_wr_en) |=> (stalled_o && $stable(rd_off_o)));

  // R6
  exec_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_valid && exe_done && !exe_stall && !reg_wr_en) |=> (rd_off_o != $past(rd_off_o)));

  // R10
  base_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && (cq_reg_e'(reg_wr_sel) == REG_BASE) && enable_o) |=> $stable(wr_off_o));

  // R13
  stall_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled_o && !reg_wr_en) |=> stalled_o);

endmodule

bind cmdq_consumer cmdq_consumer_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err),
  .exe_valid(exe_valid), .exe_done(exe_done), .exe_stall(exe_stall),
  .enable_o(enable_o), .stalled_o(stalled_o), .rd_off_o(rd_off_o), .wr_off_o(wr_off_o)
);

// File: tb/tb_cmdq_consumer.sv
module tb_cmdq_consumer;

  localparam int OFF_W = 15;
  localparam logic [63:0] VALID_BIT = 64'h8000_0000_0000_0000;
  localparam logic [51:0] BASE_A    = 52'h0_0ABC_D000;
  localparam logic [51:0] BASE_B    = 52'h0_0123_4000;

  logic              clk;
  logic              rst_n;
  logic              reg_wr_en;
  logic [1:0]        reg_wr_sel;
  logic [63:0]       reg_wr_data;
  logic              sec_disable;
  logic              mem_req;
  logic [51:0]       mem_addr;
  logic              mem_ack;
  logic              mem_err;
  logic [63:0]       mem_rdata;
  logic              exe_valid;
  logic [7:0]        exe_op;
  logic [63:0]       exe_dword;
  logic [51:0]       exe_addr;
  logic              exe_done;
  logic              exe_stall;
  logic              enable_o;
  logic              stalled_o;
  logic [OFF_W-1:0]  rd_off_o;
  logic [OFF_W-1:0]  wr_off_o;

  cmdq_consumer dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .sec_disable(sec_disable),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .exe_valid(exe_valid), .exe_op(exe_op),
    .exe_dword(exe_dword), .exe_addr(exe_addr), .exe_done(exe_done),
    .exe_stall(exe_stall), .enable_o(enable_o), .stalled_o(stalled_o),
    .rd_off_o(rd_off_o), .wr_off_o(wr_off_o)
  );

  int n_checks = 0;
  int n_errs   = 0;

  logic [7:0]  mem_op  [256];
  logic        mem_bad [256];
  logic [51:0] cur_base;
  int          fetch_cnt;
  int          exe_cnt;
  logic [51:0] exe_addr_log [16];
  logic [7:0]  exe_op_log   [16];
  logic [63:0] exe_dw_log   [16];
  logic        stall_on;
  logic [7:0]  stall_op;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Memory responder: one-cycle latency, entry index relative to cur_base.
  initial begin : mem_model
    logic [7:0] idx;
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0; mem_err = 1'b0;
      end else if (rst_n && mem_req) begin
        idx       = 8'((mem_addr - cur_base) >> 5);
        mem_ack   = 1'b1;
        mem_err   = mem_bad[idx];
        mem_rdata = {40'(idx), 16'h5A00, mem_op[idx]};
        fetch_cnt++;
      end
    end
  end

  // Executor responder: records each offered command.
  initial begin : exe_model
    exe_done = 1'b0; exe_stall = 1'b0;
    forever begin
      @(negedge clk);
      if (exe_done) begin
        exe_done = 1'b0; exe_stall = 1'b0;
      end else if (rst_n && exe_valid) begin
        if (exe_cnt < 16) begin
          exe_addr_log[exe_cnt] = exe_addr;
          exe_op_log[exe_cnt]   = exe_op;
          exe_dw_log[exe_cnt]   = exe_dword;
        end
        exe_cnt++;
        exe_done  = 1'b1;
        exe_stall = stall_on && (exe_op == stall_op);
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [63:0] data);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic clear_logs();
    fetch_cnt = 0;
    exe_cnt   = 0;
  endtask

  function automatic logic [63:0] idx_word(input int i);
    return 64'(i) << 5;
  endfunction

  function automatic logic [63:0] base_word(input logic [51:0] b, input logic v, input logic [7:0] sz);
    return (v ? VALID_BIT : 64'h0) | {12'h0, b} | {56'h0, sz};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_sel = '0; reg_wr_data = '0;
    sec_disable = 1'b0; stall_on = 1'b0; stall_op = 8'h00;
    cur_base = BASE_A;
    for (int i = 0; i < 256; i++) begin mem_op[i] = 8'h03; mem_bad[i] = 1'b0; end
    clear_logs();
    idle(3);
    rst_n = 1'b1;
    idle(2);
    check("R1 enable", 64'(enable_o), 64'h0);
    check("R1 stalled", 64'(stalled_o), 64'h0);
    check("R1 rd", 64'(rd_off_o), 64'h0);
    check("R1 wr", 64'(wr_off_o), 64'h0);
    check("R1 idle bus", 64'({mem_req, exe_valid}), 64'h0);
  endtask

  task automatic t_disabled();
    reg_write(2'd1, base_word(BASE_A, 1'b1, 8'd0));
    clear_logs();
    reg_write(2'd2, idx_word(3));
    idle(20);
    check("R2 no fetch", 64'(fetch_cnt), 64'd0);
    check("R9 wr index", 64'(wr_off_o), 64'd3);
    check("R2 rd held", 64'(rd_off_o), 64'd0);
  endtask

  task automatic t_enable_run();
    mem_op[0] = 8'h03; mem_op[1] = 8'h08; mem_op[2] = 8'h0A;
    clear_logs();
    reg_write(2'd0, 64'h1);
    idle(40);
    check("R11 enable", 64'(enable_o), 64'h1);
    check("R5 dispatch count", 64'(exe_cnt), 64'd3);
    check("R4 addr0", 64'(exe_addr_log[0]), 64'(BASE_A));
    check("R4 addr1", 64'(exe_addr_log[1]), 64'(BASE_A + 52'd32));
    check("R4 addr2", 64'(exe_addr_log[2]), 64'(BASE_A + 52'd64));
    check("R5 op0", 64'(exe_op_log[0]), 64'h03);
    check("R5 op1", 64'(exe_op_log[1]), 64'h08);
    check("R5 op2", 64'(exe_op_log[2]), 64'h0A);
    check("R5 dword", exe_dw_log[2], {40'd2, 16'h5A00, 8'h0A});
    check("R6 rd", 64'(rd_off_o), 64'd3);
    check("R6 stalled", 64'(stalled_o), 64'h0);
  endtask

  task automatic t_skip_codes();
    mem_op[3] = 8'h05; mem_op[4] = 8'h7E; mem_op[5] = 8'h00;
    clear_logs();
    reg_write(2'd2, idx_word(6));
    idle(30);
    check("R5 skip fetches", 64'(fetch_cnt), 64'd3);
    check("R5 skip no dispatch", 64'(exe_cnt), 64'd0);
    check("R6 rd after skip", 64'(rd_off_o), 64'd6);
  endtask

  task automatic t_exec_stall();
    mem_op[6] = 8'h09; stall_on = 1'b1; stall_op = 8'h09;
    clear_logs();
    reg_write(2'd2, idx_word(7));
    idle(20);
    check("R7 stalled", 64'(stalled_o), 64'h1);
    check("R7 rd held", 64'(rd_off_o), 64'd6);
    check("R7 one dispatch", 64'(exe_cnt), 64'd1);
    reg_write(2'd2, idx_word(7) | 64'h1);
    idle(20);
    check("R9 retry fetch", 64'(fetch_cnt), 64'd2);
    check("R9 retry bit ignored", 64'(wr_off_o), 64'd7);
    stall_on = 1'b0;
    reg_write(2'd2, idx_word(7));
    idle(20);
    check("R6 rd after retry", 64'(rd_off_o), 64'd7);
    check("R13 sticky", 64'(stalled_o), 64'h1);
    sec_disable = 1'b0;
    reg_write(2'd3, idx_word(2));
    idle(2);
    check("R12 blocked rd", 64'(rd_off_o), 64'd7);
    check("R12 blocked stall", 64'(stalled_o), 64'h1);
    sec_disable = 1'b1;
    reg_write(2'd3, idx_word(7) | 64'h1);
    sec_disable = 1'b0;
    idle(2);
    check("R12 rd written", 64'(rd_off_o), 64'd7);
    check("R12 stall cleared", 64'(stalled_o), 64'h0);
  endtask

  task automatic t_fetch_error();
    mem_bad[7] = 1'b1;
    clear_logs();
    reg_write(2'd2, idx_word(8));
    idle(20);
    check("R8 stalled", 64'(stalled_o), 64'h1);
    check("R8 rd held", 64'(rd_off_o), 64'd7);
    check("R8 no dispatch", 64'(exe_cnt), 64'd0);
    check("R8 one fetch", 64'(fetch_cnt), 64'd1);
    mem_bad[7] = 1'b0;
  endtask

  task automatic t_base_rules();
    reg_write(2'd1, base_word(BASE_B, 1'b1, 8'd0));
    idle(2);
    check("R10 locked wr", 64'(wr_off_o), 64'd8);
    check("R10 locked stall", 64'(stalled_o), 64'h1);
    reg_write(2'd0, 64'h0);
    check("R11 disabled", 64'(enable_o), 64'h0);
    reg_write(2'd1, base_word(BASE_A, 1'b1, 8'd0));
    idle(2);
    check("R10 rd zero", 64'(rd_off_o), 64'd0);
    check("R10 wr zero", 64'(wr_off_o), 64'd0);
    check("R10 stall clear", 64'(stalled_o), 64'h0);
  endtask

  task automatic t_wrap();
    reg_write(2'd0, 64'h1);
    idle(5);
    sec_disable = 1'b1;
    reg_write(2'd3, idx_word(126));
    sec_disable = 1'b0;
    clear_logs();
    reg_write(2'd2, idx_word(1));
    idle(40);
    check("R6 wrap count", 64'(exe_cnt), 64'd3);
    check("R4 wrap addr126", 64'(exe_addr_log[0]), 64'(BASE_A + 52'd4032));
    check("R4 wrap addr127", 64'(exe_addr_log[1]), 64'(BASE_A + 52'd4064));
    check("R6 wrap addr0", 64'(exe_addr_log[2]), 64'(BASE_A));
    check("R6 wrap rd", 64'(rd_off_o), 64'd1);
  endtask

  task automatic t_range();
    clear_logs();
    reg_write(2'd2, idx_word(200));
    idle(20);
    check("R3 out of range no fetch", 64'(fetch_cnt), 64'd0);
    check("R3 rd unchanged", 64'(rd_off_o), 64'd1);
    reg_write(2'd0, 64'h0);
    reg_write(2'd1, base_word(BASE_A, 1'b1, 8'd1));
    reg_write(2'd0, 64'h1);
    sec_disable = 1'b1;
    reg_write(2'd3, idx_word(199));
    sec_disable = 1'b0;
    clear_logs();
    reg_write(2'd2, idx_word(200));
    idle(20);
    check("R3 two pages fetch", 64'(fetch_cnt), 64'd1);
    check("R3 two pages rd", 64'(rd_off_o), 64'd200);
    reg_write(2'd0, 64'h0);
    clear_logs();
    reg_write(2'd2, idx_word(210));
    idle(20);
    check("R11 disable stops", 64'(fetch_cnt), 64'd0);
    reg_write(2'd1, base_word(BASE_A, 1'b0, 8'd0));
    reg_write(2'd0, 64'h1);
    clear_logs();
    reg_write(2'd2, idx_word(1));
    idle(20);
    check("R3 invalid base", 64'(fetch_cnt), 64'd0);
  endtask

  initial begin : main
    t_reset();
    t_disabled();
    t_enable_run();
    t_skip_codes();
    t_exec_stall();
    t_fetch_error();
    t_base_rules();
    t_wrap();
    t_range();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

endmodule